// File: doc/BRIEF.md
# Dual-Protocol Character LCD Host Port

This block is the host-facing register port of a character LCD controller. A host processor reaches it over a parallel bus that speaks one of two protocols. One uses a read/write level qualified by an enable pulse. The other uses separate active-low write and read strobes. A static pin chooses the protocol. The bus strobes and data lines are brought into the internal clock domain through two flip-flops. A byte is committed when its strobe ends.

A register-select line steers each transfer. With it low, a write is handed to the instruction path and a read returns a status byte. With it high, a write goes into the display RAM at the address counter and a read comes from the RAM. The address counter steps after every RAM byte. Data reads come from an output register that is filled ahead of time. After an address load or a data write, the first data read is a dummy that returns stale data and primes the register.

A width level from the instruction path selects full 8-bit transfers or 4-bit transfers on the upper four lines. In 4-bit mode every byte takes two transfers, upper nibble first.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the address counter is 0 and the next 4-bit transfer is taken as an upper nibble. No write pulse is issued and the bus is not driven.
- R2: With `bus_mode_6800` low, a write is committed when `rw_wr` (active-low write strobe) rises. While `e_rd` (active-low read strobe) is low, the port drives the bus.
- R3: With `bus_mode_6800` high, a write is committed when `e_rd` (enable) falls while `rw_wr` is 0. While `e_rd` is 1 and `rw_wr` is 1, the port drives the bus.
- R4: While `cs_n` is high, strobes are ignored. Nothing is written, the address counter keeps its value and the bus is not driven.
- R5: A committed byte with `rs`=0 gives a one-cycle `ir_wr` pulse carrying the byte on `ir_data`. With `rs`=1 it gives a one-cycle `ram_wr` pulse with `ram_addr` equal to the address counter. The two pulses are never asserted together.
- R6: A read with `rs`=0 returns a status byte. Bit 7 is `busy` and bits 6..0 are the address counter.
- R7: `ac_load` sets the address counter to `ac_load_val`. The counter then increments by one after each data byte written and after each non-dummy data byte read. It wraps from 127 to 0.
- R8: The first data byte read after an address load or a data write is a dummy. It returns the output register's previous contents and leaves the counter unchanged. Each following read returns the RAM byte at the counter and then advances the counter.
- R9: With `width8`=0, each byte takes two transfers on DB7..DB4, upper nibble first. DB3..DB0 of `db_in` are ignored, and `db_oe_lo` stays low during reads.
- R10: Any change of `width8` resets the nibble sequencing to the upper nibble, so a half-transferred byte is discarded.
- R11: With `width8`=1, a read drives all eight lines (`db_oe_hi` and `db_oe_lo` both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_6800 | input | 1 | Static protocol select: 1 enable-style, 0 split strobes |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 1 data, 0 instruction/status |
| rw_wr | input | 1 | Read/write level (enable style) or write strobe, active low |
| e_rd | input | 1 | Enable (enable style) or read strobe, active low |
| db_in | input | 8 | Bus data from host |
| db_out | output | 8 | Bus data to host |
| db_oe_hi | output | 1 | Drive enable for DB7..DB4 |
| db_oe_lo | output | 1 | Drive enable for DB3..DB0 |
| width8 | input | 1 | Data-length level: 1 8-bit, 0 4-bit |
| busy | input | 1 | Internal operation in progress |
| ac_load | input | 1 | Address-set pulse from instruction execution |
| ac_load_val | input | 7 | Address to load |
| ir_wr | output | 1 | Instruction byte strobe |
| ir_data | output | 8 | Instruction byte |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | Output-register refill strobe |
| ram_addr | output | 7 | RAM address (address counter) |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data at `ram_addr`, same cycle |

## Verification
The assertions assume the host keeps `rs`, `rw_wr` and `db_in` steady for several clocks around each strobe edge. They also assume the protocol pin only changes while reset is held, and that both strobes are never active together in split-strobe mode. The bench's transfer tasks set up select, direction and data two or more cycles before the strobe and hold them five cycles after it. The protocol is changed only inside a reset sequence. The RAM model answers in the same cycle, as the refill timing expects.

// File: rtl/lcd_host_port.sv
module lcd_host_port #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode_6800,
  input  logic              cs_n,
  input  logic              rs,
  input  logic              rw_wr,
  input  logic              e_rd,
  input  logic [7:0]        db_in,
  output logic [7:0]        db_out,
  output logic              db_oe_hi,
  output logic              db_oe_lo,
  input  logic              width8,
  input  logic              busy,
  input  logic              ac_load,
  input  logic [ADDR_W-1:0] ac_load_val,
  output logic              ir_wr,
  output logic [7:0]        ir_data,
  output logic              ram_wr,
  output logic              ram_rd,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);

  localparam logic [ADDR_W-1:0] AC_ONE = ADDR_W'(1);

  logic [2:0] cs_q, rs_q, rw_q, en_q;
  logic [7:0] d0_q, d1_q;
  logic       width_q, hi_done, rd_done, prefetch_ok;
  logic [3:0] nib_hold;
  logic [ADDR_W-1:0] ac;
  logic [7:0] oreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 3'b111;
      rs_q <= 3'b000;
      rw_q <= {3{~bus_mode_6800}};
      en_q <= {3{~bus_mode_6800}};
      d0_q <= '0;
      d1_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], cs_n};
      rs_q <= {rs_q[1:0], rs};
      rw_q <= {rw_q[1:0], rw_wr};
      en_q <= {en_q[1:0], e_rd};
      d0_q <= db_in;
      d1_q <= d0_q;
    end

  wire sel    = ~cs_q[1];
  wire en_end = en_q[2] & ~en_q[1];
  wire wr_end = sel & (bus_mode_6800 ? en_end & ~rw_q[1] : ~rw_q[2] & rw_q[1]);
  wire rd_end = sel & (bus_mode_6800 ? en_end &  rw_q[1] : ~en_q[2] & en_q[1]);
  wire rd_on  = sel & (bus_mode_6800 ? en_q[1] & rw_q[1] : ~en_q[1]);

  wire       width_chg = width8 != width_q;
  wire       byte_wr   = wr_end & (width8 | hi_done);
  wire       byte_rd   = rd_end & (width8 | hi_done);
  wire [7:0] wbyte     = width8 ? d1_q : {nib_hold, d1_q[7:4]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      width_q  <= 1'b1;
      hi_done  <= 1'b0;
      nib_hold <= '0;
    end else begin
      width_q <= width8;
      if (width_chg)
        hi_done <= 1'b0;
      else if (!width8 && (wr_end || rd_end))
        hi_done <= ~hi_done;
      if (!width8 && wr_end && !hi_done)
        nib_hold <= d1_q[7:4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir_wr     <= 1'b0;
      ram_wr    <= 1'b0;
      rd_done   <= 1'b0;
      ram_rd    <= 1'b0;
      ir_data   <= '0;
      ram_wdata <= '0;
    end else begin
      ir_wr   <= byte_wr & ~rs_q[1];
      ram_wr  <= byte_wr &  rs_q[1];
      rd_done <= byte_rd &  rs_q[1];
      ram_rd  <= rd_done & ~ac_load;
      if (byte_wr) begin
        ir_data   <= wbyte;
        ram_wdata <= wbyte;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ac          <= '0;
      prefetch_ok <= 1'b0;
      oreg        <= '0;
    end else begin
      if (ac_load)
        ac <= ac_load_val;
      else if (ram_wr || (rd_done && prefetch_ok))
        ac <= ac + AC_ONE;
      if (ac_load || ram_wr)
        prefetch_ok <= 1'b0;
      else if (rd_done)
        prefetch_ok <= 1'b1;
      if (ram_rd)
        oreg <= ram_rdata;
    end

  assign ram_addr = ac;

  wire [7:0] rbyte = rs_q[1] ? oreg : {busy, 7'(ac)};
  assign db_out   = width8 ? rbyte : {(hi_done ? rbyte[3:0] : rbyte[7:4]), 4'b0000};
  assign db_oe_hi = rd_on;
  assign db_oe_lo = rd_on & width8;

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ir_wr && ram_wr));

  assert_ac_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr && !ac_load |=> ac == ADDR_W'($past(ac) + AC_ONE));

  assert_dummy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !prefetch_ok && !ac_load && !ram_wr |=> ac == $past(ac));

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !db_oe_hi);

  assert_lo_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !width8 |-> !db_oe_lo);

endmodule

// File: tb/test_lcd_host_port.sv
module test_lcd_host_port;
  logic       clk = 1'b0, rst_n = 1'b0, m68 = 1'b0;
  logic       cs_n = 1'b1, rs = 1'b0, rw_wr = 1'b1, e_rd = 1'b1;
  logic [7:0] db_in = '0, db_out, ir_data, ram_wdata, ram_rdata;
  logic       db_oe_hi, db_oe_lo, width8 = 1'b1, busy = 1'b0;
  logic       ac_load = 1'b0, ir_wr, ram_wr, ram_rd, fill = 1'b0;
  logic [6:0] ac_load_val = '0, ram_addr;
  logic [7:0] mem [128];
  int         checks = 0, fails = 0, ir_cnt = 0;
  logic [7:0] ir_last = '0;

  always #10 clk = ~clk;

  lcd_host_port i_lcd_host_port (
    .clk(clk), .rst_n(rst_n), .bus_mode_6800(m68), .cs_n(cs_n), .rs(rs),
    .rw_wr(rw_wr), .e_rd(e_rd), .db_in(db_in), .db_out(db_out),
    .db_oe_hi(db_oe_hi), .db_oe_lo(db_oe_lo), .width8(width8), .busy(busy),
    .ac_load(ac_load), .ac_load_val(ac_load_val), .ir_wr(ir_wr),
    .ir_data(ir_data), .ram_wr(ram_wr), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata));

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (fill) for (int i = 0; i < 128; i++) mem[i] <= pat(i);
    else if (ram_wr) mem[ram_addr] <= ram_wdata;
    if (ir_wr) begin ir_cnt <= ir_cnt + 1; ir_last <= ir_data; end
  end
  assign ram_rdata = mem[ram_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; m68 = mode; cs_n = 1'b1; width8 = 1'b1;
    rw_wr = 1'b1; e_rd = mode ? 1'b0 : 1'b1;
    fill = 1'b1;
    repeat (3) @(negedge clk);
    fill = 1'b0; rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xfer(input bit sel, input bit is_rd, input logic r, input logic [7:0] v,
                      output logic [7:0] got, output logic oh, output logic ol);
    @(negedge clk);
    cs_n = ~sel; rs = r; db_in = v;
    if (m68) rw_wr = is_rd;
    repeat (2) @(negedge clk);
    if (m68) e_rd = 1'b1; else if (is_rd) e_rd = 1'b0; else rw_wr = 1'b0;
    repeat (4) @(negedge clk);
    got = db_out; oh = db_oe_hi; ol = db_oe_lo;
    if (m68) e_rd = 1'b0; else begin e_rd = 1'b1; rw_wr = 1'b1; end
    repeat (5) @(negedge clk);
    cs_n = 1'b1; rw_wr = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_byte(input logic r, input logic [7:0] b);
    logic [7:0] g; logic oh, ol;
    if (width8) xfer(1, 0, r, b, g, oh, ol);
    else begin
      xfer(1, 0, r, {b[7:4], 4'h5}, g, oh, ol);
      xfer(1, 0, r, {b[3:0], 4'hA}, g, oh, ol);
    end
  endtask

  task automatic rd_byte(input logic r, output logic [7:0] b);
    logic [7:0] g; logic oh, ol;
    if (width8) begin
      xfer(1, 1, r, 8'h00, b, oh, ol);
      check(oh && ol, "R11 both halves driven", {oh, ol}, 3);
    end else begin
      xfer(1, 1, r, 8'h00, g, oh, ol);
      b[7:4] = g[7:4];
      check(oh && !ol, "R9 low lines undriven", {oh, ol}, 2);
      xfer(1, 1, r, 8'h00, g, oh, ol);
      b[3:0] = g[7:4];
    end
  endtask

  task automatic load_ac(input logic [6:0] a);
    @(negedge clk); ac_load = 1'b1; ac_load_val = a;
    @(negedge clk); ac_load = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    set_mode(0);
    check(!db_oe_hi && !db_oe_lo, "R1 bus released", {db_oe_hi, db_oe_lo}, 0);
    check(!ir_wr && !ram_wr, "R1 no pulses", {ir_wr, ram_wr}, 0);
    rd_byte(0, s);
    check(s == 8'h00, "R1 status after reset", s, 0);
  endtask

  task automatic t_split_strobes;
    logic [7:0] s;
    int n0;
    n0 = ir_cnt;
    wr_byte(0, 8'h3C);
    check(ir_cnt == n0 + 1 && ir_last == 8'h3C, "R2 R5 instruction write", ir_last, 8'h3C);
    load_ac(7'd10);
    wr_byte(1, 8'h11);
    wr_byte(1, 8'h22);
    rd_byte(0, s);
    check(s == 8'h0C, "R7 counter after two writes", s, 8'h0C);
    check(ir_cnt == n0 + 1, "R5 data writes skip instruction path", ir_cnt, n0 + 1);
    load_ac(7'd10);
    rd_byte(1, s);
    check(s == 8'h00, "R8 dummy returns stale", s, 0);
    rd_byte(0, s);
    check(s == 8'h0A, "R8 dummy keeps counter", s, 8'h0A);
    rd_byte(1, s);
    check(s == 8'h11, "R8 first valid read", s, 8'h11);
    rd_byte(1, s);
    check(s == 8'h22, "R8 second valid read", s, 8'h22);
    rd_byte(0, s);
    check(s == 8'h0C, "R7 counter after reads", s, 8'h0C);
    load_ac(7'd20);
    rd_byte(1, s);
    check(s == pat(12), "R8 stale is previous prefetch", s, pat(12));
  endtask

  task automatic t_busy;
    logic [7:0] s;
    busy = 1'b1;
    load_ac(7'd33);
    rd_byte(0, s);
    check(s == 8'hA1, "R6 busy and counter", s, 8'hA1);
    busy = 1'b0;
  endtask

  task automatic t_enable_style;
    logic [7:0] s;
    set_mode(1);
    wr_byte(0, 8'h5A);
    check(ir_last == 8'h5A, "R3 enable-style write", ir_last, 8'h5A);
    load_ac(7'd3);
    rd_byte(1, s);
    rd_byte(1, s);
    check(s == pat(3), "R3 enable-style read", s, pat(3));
  endtask

  task automatic t_deselect;
    logic [7:0] g, s; logic oh, ol;
    int n0;
    n0 = ir_cnt;
    load_ac(7'd50);
    xfer(0, 0, 1, 8'hEE, g, oh, ol);
    xfer(0, 0, 0, 8'hEE, g, oh, ol);
    check(ir_cnt == n0, "R4 no instruction when deselected", ir_cnt, n0);
    xfer(0, 1, 0, 8'h00, g, oh, ol);
    check(!oh && !ol, "R4 bus not driven when deselected", {oh, ol}, 0);
    rd_byte(0, s);
    check(s == 8'd50, "R4 counter unchanged", s, 50);
    load_ac(7'd50);
    rd_byte(1, s);
    rd_byte(1, s);
    check(s == pat(50), "R4 RAM untouched", s, pat(50));
  endtask

  task automatic t_nibbles;
    logic [7:0] s;
    width8 = 1'b0;
    repeat (3) @(negedge clk);
    wr_byte(0, 8'hA7);
    check(ir_last == 8'hA7, "R9 nibble instruction write", ir_last, 8'hA7);
    load_ac(7'd40);
    wr_byte(1, 8'hC3);
    load_ac(7'd40);
    rd_byte(1, s);
    rd_byte(1, s);
    check(s == 8'hC3, "R9 nibble data read", s, 8'hC3);
    rd_byte(0, s);
    check(s == 8'd41, "R9 status in nibbles", s, 41);
  endtask

  task automatic t_width_change;
    logic [7:0] g; logic oh, ol;
    int n0;
    n0 = ir_cnt;
    xfer(1, 0, 0, 8'h90, g, oh, ol);
    width8 = 1'b1;
    repeat (3) @(negedge clk);
    width8 = 1'b0;
    repeat (3) @(negedge clk);
    wr_byte(0, 8'h6B);
    check(ir_last == 8'h6B, "R10 half byte discarded", ir_last, 8'h6B);
    check(ir_cnt == n0 + 1, "R10 single instruction", ir_cnt, n0 + 1);
    width8 = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_wrap;
    logic [7:0] s;
    load_ac(7'd127);
    wr_byte(1, 8'h01);
    rd_byte(0, s);
    check(s == 8'h00, "R7 counter wraps", s, 0);
  endtask

  bit done = 1'b0;
  initial begin
    t_reset();
    t_split_strobes();
    t_busy();
    t_deselect();
    t_wrap();
    t_enable_style();
    t_nibbles();
    t_width_change();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule